// File: doc/BRIEF.md
# FIFO Event Interrupt Aggregator

This block gathers single-cycle FIFO event pulses from ten channels. Each channel can be a capture or a playback stream. Every pulse sets a sticky raw status bit. A per-event enable decides whether that bit shows in the masked status. A per-channel host mask then decides whether the channel's enabled events can raise the single interrupt line. Software reads the status through a word-wide register port and acknowledges events by writing ones to a clear word.

Status, enable and clear words each hold four channels. Each channel owns an 8-bit lane, so channel c sits in word c/4 at lane base (c%4)*8. There are six event types per channel, so only the low six bits of a lane are used. Event bit order within a lane:
- bit 0: capture almost-empty
- bit 1: capture almost-full
- bit 2: playback almost-empty
- bit 3: playback almost-full
- bit 4: capture overflow
- bit 5: playback overflow

The event input vector is channel-major: bit c*6+e is event e of channel c.

Register word addresses:
- 0..2: enable words (read/write).
- 3..5: clear words (write 1 to clear).
- 6..8: raw status words (read only).
- 9..11: masked status words (read only).
- 12: host mask, where bit c gates channel c.

Top module: `fifo_evt_irq_agg`

## Requirements
- R1: After reset, every readable word (addresses 0 to 12) reads zero and irq_o is low.
- R2: A pulse on event e of channel c sets bit (c%4)*8+e of raw word 6+c/4 on the next clock edge. The bit stays set after the pulse ends.
- R3: A masked status word (address 9+w) reads as raw word w ANDed with enable word w. The enable words read back what was written to their usable bits.
- R4: Writing a 1 to a bit of clear word 3+w clears the same bit of raw word w. Writing 0 to a bit leaves it unchanged.
- R5: If an event pulse and a clear of the same raw bit fall in the same cycle, the bit ends up set.
- R6: irq_o is a register. It rises on the clock edge after a masked status bit of a host-unmasked channel becomes set, and it falls one edge after no such bit remains.
- R7: A channel whose host mask bit (address 12, bit c) is 0 never drives irq_o, even with masked status set.
- R8: Lane bits 6 and 7, the lanes of non-existent channels 10 and 11, and host mask bits 10 to 31 read as zero. Writes cannot set them.
- R9: Clear words always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 60 | Event pulses, bit c*6+e |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Host interrupt line, registered |

## Verification
A wrong lane or word mapping puts a raw bit in the wrong place, and a register read shows it right after the pulse's clock edge. A lost or spuriously set sticky bit shows in the next raw or masked read. A broken clear priority shows in the read that follows the conflicting cycle. A wrong mask or enable gate shows on irq_o exactly one edge after the status change, so the line is sampled at both the early cycle and the following cycle.

// File: rtl/fifo_evt_irq_agg.sv
module fifo_evt_irq_agg #(
  parameter int NUM_CH = 10,
  parameter int EVT_N  = 6,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*EVT_N-1:0]   evt_i,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      irq_o
);

  localparam int NF       = NUM_CH * EVT_N;
  localparam int CH_PER_W = 4;
  localparam int LANE_W   = 8;
  localparam int NW       = (NUM_CH + CH_PER_W - 1) / CH_PER_W;
  localparam int EN_BASE  = 0;
  localparam int CLR_BASE = NW;
  localparam int RAW_BASE = 2 * NW;
  localparam int MSK_BASE = 3 * NW;
  localparam int HM_ADDR  = 4 * NW;

  logic [NF-1:0]     en_q, raw_q, clr, en_wr, en_d;
  logic [NUM_CH-1:0] hmask_q, ch_hit;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;

  function automatic logic [31:0] pack(input logic [NF-1:0] v, input int w);
    logic [31:0] r;
    r = '0;
    for (int c = 0; c < CH_PER_W; c++)
      if (w * CH_PER_W + c < NUM_CH)
        for (int e = 0; e < EVT_N; e++)
          r[c*LANE_W+e] = v[(w*CH_PER_W+c)*EVT_N+e];
    return r;
  endfunction

  always_comb begin
    clr   = '0;
    en_wr = '0;
    en_d  = en_q;
    for (int ch = 0; ch < NUM_CH; ch++)
      for (int e = 0; e < EVT_N; e++) begin
        if (reg_we && int'(reg_addr) == CLR_BASE + ch / CH_PER_W)
          clr[ch*EVT_N+e] = reg_wdata[(ch%CH_PER_W)*LANE_W+e];
        if (reg_we && int'(reg_addr) == EN_BASE + ch / CH_PER_W) begin
          en_wr[ch*EVT_N+e] = 1'b1;
          en_d[ch*EVT_N+e]  = reg_wdata[(ch%CH_PER_W)*LANE_W+e];
        end
      end
  end

  always_comb
    for (int ch = 0; ch < NUM_CH; ch++)
      ch_hit[ch] = hmask_q[ch] & |(raw_q[ch*EVT_N +: EVT_N] & en_q[ch*EVT_N +: EVT_N]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q    <= '0;
      raw_q   <= '0;
      hmask_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      raw_q <= evt_i | (raw_q & ~clr);
      if (|en_wr) en_q <= en_d;
      if (reg_we && int'(reg_addr) == HM_ADDR) hmask_q <= reg_wdata[NUM_CH-1:0];
      irq_o <= |ch_hit;
    end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (int'(reg_addr) == EN_BASE + w)  reg_rdata = pack(en_q, w);
      if (int'(reg_addr) == RAW_BASE + w) reg_rdata = pack(raw_q, w);
      if (int'(reg_addr) == MSK_BASE + w) reg_rdata = pack(raw_q & en_q, w);
    end
    if (int'(reg_addr) == HM_ADDR) reg_rdata = {{(32-NUM_CH){1'b0}}, hmask_q};
  end

  a_r2_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(evt_i)) == '0));

  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(raw_q & en_q)));

  a_r7_irq_needs_hmask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|hmask_q));

endmodule

// File: tb/sim_fifo_evt_irq_agg.sv
`timescale 1ns/1ps
module sim_fifo_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [59:0] evt_i = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  fifo_evt_irq_agg u0 (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 4'(a); #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [59:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  function automatic logic [59:0] ev(input int ch, input int e);
    logic [59:0] v = '0;
    v[ch*6+e] = 1'b1;
    return v;
  endfunction

  task automatic clear_all();
    for (int w = 0; w < 3; w++) wr(3 + w, 32'hFFFF_FFFF);
    wr(12, 0);
    for (int w = 0; w < 3; w++) wr(w, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 13; a++) begin
      rd(a, d); chk("R1 reset word", d, 0);
    end
    chk("R1 reset irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_set_sticky();
    logic [31:0] d;
    pulse(ev(5, 1));
    rd(7, d); chk("R2 raw ch5 evt1", d, 32'h1 << 9);
    repeat (3) @(negedge clk);
    rd(7, d); chk("R2 raw sticky", d, 32'h1 << 9);
    rd(10, d); chk("R3 masked with enable off", d, 0);
    wr(1, 32'h1 << 9);
    rd(1, d); chk("R3 enable readback", d, 32'h1 << 9);
    rd(10, d); chk("R3 masked with enable on", d, 32'h1 << 9);
  endtask

  task automatic t_host_mask();
    logic [31:0] d;
    @(negedge clk);
    chk("R7 irq low with host mask off", {31'd0, irq_o}, 0);
    wr(12, 32'h1 << 4);
    @(negedge clk);
    chk("R7 irq low with other channel unmasked", {31'd0, irq_o}, 0);
    wr(12, 32'h1 << 5);
    chk("R6 irq not yet after mask write", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R6 irq high", {31'd0, irq_o}, 1);
    rd(12, d); chk("R8 host mask readback", d, 32'h1 << 5);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(4, 32'h0);
    rd(7, d); chk("R4 write 0 no effect", d, 32'h1 << 9);
    chk("R4 irq held", {31'd0, irq_o}, 1);
    wr(4, 32'h1 << 9);
    rd(7, d); chk("R4 cleared", d, 0);
    @(negedge clk);
    chk("R6 irq falls", {31'd0, irq_o}, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    evt_i = ev(9, 5); reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h1 << 13;
    @(negedge clk);
    evt_i = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(8, d); chk("R5 set wins over clear", d, 32'h1 << 13);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    clear_all();
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); chk("R8 enable unused bits", d, 32'h0000_3F3F);
    wr(12, 32'hFFFF_FFFF);
    rd(12, d); chk("R8 host mask width", d, 32'h0000_03FF);
    pulse('1);
    rd(6, d); chk("R2 raw word0 all lanes", d, 32'h3F3F_3F3F);
    rd(8, d); chk("R2 raw word2 lanes", d, 32'h0000_3F3F);
    rd(9, d); chk("R3 masked word0 no enable", d, 0);
    for (int w = 3; w < 6; w++) begin
      rd(w, d); chk("R9 clear word reads zero", d, 0);
    end
  endtask

  task automatic t_timing();
    logic [31:0] d;
    clear_all();
    wr(0, 32'h1 << 16);
    wr(12, 32'h1 << 2);
    pulse(ev(2, 0));
    rd(6, d); chk("R2 ch2 evt0 position", d, 32'h1 << 16);
    chk("R6 irq one cycle late", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R6 irq asserted", {31'd0, irq_o}, 1);
    pulse(ev(3, 3));
    rd(6, d); chk("R2 ch3 evt3 added", d, (32'h1 << 16) | (32'h1 << 27));
    wr(3, 32'h1 << 16);
    @(negedge clk);
    chk("R7 ch3 unmasked only via own bit", {31'd0, irq_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_sticky();
    t_host_mask();
    t_w1c();
    t_set_wins();
    t_unused();
    t_timing();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule